// File: doc/BRIEF.md
# Prioritized Restart Interrupt Unit

This block is the interrupt front end of a small 8-bit processor. It collects five interrupt sources: one non-maskable trap, three maskable restart requests at high, middle and low rank, and one general request whose opcode is supplied by external logic. It owns the interrupt-enable flag, the three restart masks and the edge latch of the high-rank restart. Requests are looked at only once per instruction, on the clock edge where the sequencer raises `sample_i` (the next-to-last cycle of the instruction).

When a source is accepted at that edge, the unit drives a one-cycle response in the following cycle. The response holds the program counter, and either supplies a restart vector that is inserted internally or strobes an acknowledge so that external logic can place a restart or call opcode on the bus. Accepting any source clears the enable flag. Software writes the masks from an 8-bit accumulator value and can read pending requests, the enable flag and the masks back as one status byte.

The instruction decoder, the stack push and the fetch of the external opcode sit outside this block.

Top module: `irq_restart_unit`

## Requirements
- R1: On a sampling edge with `trap_i` high, the trap is accepted whatever the enable flag and masks are, ahead of every other source, and `vector_o` is 0x0024 with `vec_valid_o` high in the next cycle.
- R2: Below the trap the fixed order is high-rank restart, then middle-rank, then low-rank, then the general request. Only the winner is accepted.
- R3: Sources are evaluated only on a clock edge where `sample_i` is high. The response (`pc_hold_o`, `vec_valid_o`, `vector_o`, `gen_ack_o`) is valid for exactly the one cycle after that edge and is otherwise all zero.
- R4: `pc_hold_o` is high for exactly the one cycle after any accepted source and low otherwise.
- R5: The enable flag is 0 after reset. Accepting any source clears it. `ie_clr_i` clears it and `ie_set_i` sets it; clearing wins when both are active.
- R6: The three restarts and the general request are accepted only with the enable flag at 1. Each restart also needs its mask bit at 0.
- R7: Accepting the general request raises `gen_ack_o` for one cycle with `vec_valid_o` low and `vector_o` zero.
- R8: Accepted restarts give `vec_valid_o` high with `vector_o` 0x003C (high rank), 0x0034 (middle rank) and 0x002C (low rank).
- R9: A mask write with bit 3 set loads the masks from bits 2:0 (bit 2 high rank, bit 1 middle, bit 0 low). With bit 3 clear the masks keep their value. The masks are 3'b111 after reset.
- R10: A mask write with bit 4 set clears the latched high-rank request. A new rising edge on the same clock wins.
- R11: The high-rank input is latched on a rising edge and stays pending until it is accepted or cleared. The middle and low inputs act on their current level.
- R12: `status_o` is {bit 7 = 0, bit 6 = high-rank pending, bit 5 = middle input, bit 4 = low input, bit 3 = enable flag, bits 2:0 = masks}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Strobe on the next-to-last cycle of an instruction |
| trap_i | input | 1 | Non-maskable trap request |
| rq_hi_i | input | 1 | High-rank restart request, edge latched |
| rq_mid_i | input | 1 | Middle-rank restart request, level |
| rq_lo_i | input | 1 | Low-rank restart request, level |
| gen_req_i | input | 1 | General request, externally vectored |
| ie_set_i | input | 1 | Set the enable flag |
| ie_clr_i | input | 1 | Clear the enable flag |
| mask_wr_i | input | 1 | Mask write command |
| mask_data_i | input | 8 | Accumulator value for the mask write |
| status_o | output | 8 | Pending, enable and mask status |
| pc_hold_o | output | 1 | Inhibit program counter increment |
| vec_valid_o | output | 1 | Internal restart vector is valid |
| vector_o | output | 16 | Restart vector address |
| gen_ack_o | output | 1 | Acknowledge strobe for the general request |

## Verification
The hardest state to reach is a high-rank edge that is already latched and then meets one of three events: a later sampling edge, a clearing mask write on the same clock as a fresh rising edge, or a trap that pre-empts it, all while the enable flag is being re-armed. After the directed cases, long runs of random stimulus (frequent strobes, re-arming of the enable flag, occasional traps and random mask bytes) drive the unit into these overlaps. A behavioural model in the bench, which tracks the latch, the masks and the flag, then checks every response and every status byte.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;

    localparam int DATA_W  = 8;
    localparam int VEC_W   = 16;
    localparam int NUM_SRC = 5;
    localparam int NUM_RST = 3;

    // mask write byte field positions
    localparam int MW_EN_BIT    = 3;
    localparam int MW_CLRHI_BIT = 4;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_HI   = 3'd2,
        SRC_MID  = 3'd3,
        SRC_LO   = 3'd4,
        SRC_GEN  = 3'd5
    } src_e;

    localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_HI   = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_MID  = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LO   = 16'h002C;

    typedef struct packed {
        logic             take;
        logic             internal;
        logic             ext_ack;
        logic [VEC_W-1:0] vec;
    } accept_t;

    function automatic logic [VEC_W-1:0] vector_of(src_e s);
        case (s)
            SRC_TRAP: return VEC_TRAP;
            SRC_HI:   return VEC_HI;
            SRC_MID:  return VEC_MID;
            SRC_LO:   return VEC_LO;
            default:  return '0;
        endcase
    endfunction

    function automatic logic is_internal(src_e s);
        return (s == SRC_TRAP) || (s == SRC_HI) || (s == SRC_MID) || (s == SRC_LO);
    endfunction

    function automatic accept_t make_accept(src_e s);
        accept_t a;
        a.take     = (s != SRC_NONE);
        a.internal = is_internal(s);
        a.ext_ack  = (s == SRC_GEN);
        a.vec      = vector_of(s);
        return a;
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    input  logic clear_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = level_i && !prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= level_i;
            if (rise)
                pend_q <= 1'b1;
            else if (clear_i)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R11: a rising edge always leaves the request pending
    assert_edge_capture_R11: assert property (@(posedge clk) disable iff (rst)
        (level_i && !prev_q) |=> pend_q);

    // R11: a pending request stays pending until something clears it
    assert_pend_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clear_i) |=> pend_q);

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_front_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               ie_set_i,
    input  logic               ie_clr_i,
    input  logic               take_i,
    output logic [NUM_RST-1:0] mask_o,
    output logic               ie_o
);
    logic [NUM_RST-1:0] mask_q;
    logic               ie_q;
    logic               load_mask;

    assign load_mask = wr_i && wdata_i[MW_EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            ie_q   <= 1'b0;
        end else begin
            if (load_mask)
                mask_q <= wdata_i[NUM_RST-1:0];
            if (take_i || ie_clr_i)
                ie_q <= 1'b0;
            else if (ie_set_i)
                ie_q <= 1'b1;
        end
    end

    assign mask_o = mask_q;
    assign ie_o   = ie_q;

    // R5: acceptance always leaves the enable flag cleared
    assert_ie_drop_R5: assert property (@(posedge clk) disable iff (rst)
        take_i |=> !ie_q);

    // R9: masks only change through an enabled mask write
    assert_mask_keep_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && wdata_i[MW_EN_BIT]) |=> $stable(mask_q));

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_front_pkg::*;
(
    input  logic [NUM_SRC-1:0] req_i,
    output src_e               winner_o
);
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] above;

    assign above[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign grant[g] = req_i[g] && !above[g];
        if (g < NUM_SRC - 1) begin : g_next
            assign above[g+1] = above[g] || req_i[g];
        end
    end

    always_comb begin
        winner_o = SRC_NONE;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (grant[k])
                winner_o = src_e'(3'(k + 1));
        end
    end

    // R2: never more than one source granted
    always_comb begin
        assert_single_grant_R2: assert ($onehot0(grant));
    end

endmodule

// File: rtl/irq_restart_unit.sv
module irq_restart_unit
    import irq_front_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_i,
    input  logic        trap_i,
    input  logic        rq_hi_i,
    input  logic        rq_mid_i,
    input  logic        rq_lo_i,
    input  logic        gen_req_i,
    input  logic        ie_set_i,
    input  logic        ie_clr_i,
    input  logic        mask_wr_i,
    input  logic [7:0]  mask_data_i,
    output logic [7:0]  status_o,
    output logic        pc_hold_o,
    output logic        vec_valid_o,
    output logic [15:0] vector_o,
    output logic        gen_ack_o
);
    logic [NUM_RST-1:0] mask;
    logic               ie;
    logic               pend_hi;
    logic               clear_hi;
    logic [NUM_SRC-1:0] req;
    src_e               winner;
    accept_t            acc_d;
    accept_t            acc_q;
    logic               unused_mw;

    assign unused_mw = &{1'b0, mask_data_i[DATA_W-1:MW_CLRHI_BIT+1]};

    // request vector, index 0 is the highest priority
    always_comb begin
        req    = '0;
        req[0] = trap_i;
        req[1] = ie && pend_hi  && !mask[2];
        req[2] = ie && rq_mid_i && !mask[1];
        req[3] = ie && rq_lo_i  && !mask[0];
        req[4] = ie && gen_req_i;
        if (!sample_i)
            req = '0;
    end

    irq_prio_arb u_arb (
        .req_i    (req),
        .winner_o (winner)
    );

    assign acc_d    = make_accept(winner);
    assign clear_hi = (winner == SRC_HI) || (mask_wr_i && mask_data_i[MW_CLRHI_BIT]);

    irq_edge_latch u_hi_latch (
        .clk     (clk),
        .rst     (rst),
        .level_i (rq_hi_i),
        .clear_i (clear_hi),
        .pend_o  (pend_hi)
    );

    irq_mask_ctrl u_mask (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (mask_wr_i),
        .wdata_i  (mask_data_i),
        .ie_set_i (ie_set_i),
        .ie_clr_i (ie_clr_i),
        .take_i   (acc_d.take),
        .mask_o   (mask),
        .ie_o     (ie)
    );

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    assign pc_hold_o   = acc_q.take;
    assign vec_valid_o = acc_q.internal;
    assign gen_ack_o   = acc_q.ext_ack;
    assign vector_o    = acc_q.vec;
    assign status_o    = {1'b0, pend_hi, rq_mid_i, rq_lo_i, ie, mask};

    // R1: trap on a sampling edge always answers with its vector
    assert_trap_wins_R1: assert property (@(posedge clk) disable iff (rst)
        (sample_i && trap_i) |=> (pc_hold_o && vec_valid_o && vector_o == VEC_TRAP));

    // R3: no response without a sampling edge
    assert_only_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !sample_i |=> (!pc_hold_o && !vec_valid_o && !gen_ack_o));

    // R4: the response lasts one cycle, since strobes do not repeat back to back here
    assert_hold_single_R4: assert property (@(posedge clk) disable iff (rst)
        (pc_hold_o && !sample_i) |=> !pc_hold_o);

    // R6: with the flag clear only the trap gets through
    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (sample_i && !trap_i && !status_o[3]) |=> !pc_hold_o);

    // R7: the general acknowledge never comes with an internal vector
    assert_ack_no_vec_R7: assert property (@(posedge clk) disable iff (rst)
        gen_ack_o |-> (pc_hold_o && !vec_valid_o && vector_o == 16'h0000));

endmodule

// File: tb/test_irq_restart_unit.sv
module test_irq_restart_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_i = 0, trap_i = 0, rq_hi_i = 0, rq_mid_i = 0, rq_lo_i = 0;
    logic        gen_req_i = 0, ie_set_i = 0, ie_clr_i = 0, mask_wr_i = 0;
    logic [7:0]  mask_data_i = 8'h00;
    logic [7:0]  status_o;
    logic        pc_hold_o, vec_valid_o, gen_ack_o;
    logic [15:0] vector_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_restart_unit i_irq_restart_unit (
        .clk(clk), .rst(rst), .sample_i(sample_i), .trap_i(trap_i),
        .rq_hi_i(rq_hi_i), .rq_mid_i(rq_mid_i), .rq_lo_i(rq_lo_i),
        .gen_req_i(gen_req_i), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
        .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i), .status_o(status_o),
        .pc_hold_o(pc_hold_o), .vec_valid_o(vec_valid_o), .vector_o(vector_o),
        .gen_ack_o(gen_ack_o)
    );

    // behavioural reference model
    bit       m_ie, m_pend, m_prev;
    bit [2:0] m_mask;
    bit       e_hold, e_vv, e_ack;
    bit [15:0] e_vec;

    always @(posedge clk) begin
        int choice;
        bit rise, clr;
        if (rst) begin
            m_ie = 0; m_mask = 3'b111; m_pend = 0; m_prev = 0;
            e_hold = 0; e_vv = 0; e_ack = 0; e_vec = 0;
        end else begin
            choice = 0;
            if (sample_i) begin
                if (trap_i) choice = 1;
                else if (m_ie && m_pend && !m_mask[2]) choice = 2;
                else if (m_ie && rq_mid_i && !m_mask[1]) choice = 3;
                else if (m_ie && rq_lo_i && !m_mask[0]) choice = 4;
                else if (m_ie && gen_req_i) choice = 5;
            end
            e_hold = (choice != 0);
            e_vv   = (choice >= 1 && choice <= 4);
            e_ack  = (choice == 5);
            case (choice)
                1: e_vec = 16'h0024;
                2: e_vec = 16'h003C;
                3: e_vec = 16'h0034;
                4: e_vec = 16'h002C;
                default: e_vec = 16'h0000;
            endcase
            rise = rq_hi_i && !m_prev;
            clr  = (choice == 2) || (mask_wr_i && mask_data_i[4]);
            if (rise) m_pend = 1; else if (clr) m_pend = 0;
            m_prev = rq_hi_i;
            if (mask_wr_i && mask_data_i[3]) m_mask = mask_data_i[2:0];
            if (choice != 0 || ie_clr_i) m_ie = 0; else if (ie_set_i) m_ie = 1;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 model hold", 32'(pc_hold_o), 32'(e_hold));
            chk("R8 model vector", 32'(vector_o), 32'(e_vec));
            chk("R8 model vec_valid", 32'(vec_valid_o), 32'(e_vv));
            chk("R7 model ack", 32'(gen_ack_o), 32'(e_ack));
            chk("R12 model status", 32'(status_o),
                32'({1'b0, m_pend, rq_mid_i, rq_lo_i, m_ie, m_mask}));
        end
    end

    task automatic tick();
        @(negedge clk);
        ie_set_i = 0; ie_clr_i = 0; mask_wr_i = 0; sample_i = 0;
    endtask

    task automatic strobe();
        sample_i = 1;
        tick();
    endtask

    task automatic arm();
        ie_set_i = 1;
        tick();
    endtask

    task automatic mwrite(logic [7:0] d);
        mask_wr_i = 1; mask_data_i = d;
        tick();
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        tick();
        chk("R12 R9 R5 reset status", 32'(status_o), 32'h07);
        chk("R4 reset hold", 32'(pc_hold_o), 0);

        gen_req_i = 1; strobe();
        chk("R6 gen blocked with flag clear", 32'(pc_hold_o), 0);
        gen_req_i = 0;

        trap_i = 1; strobe();
        chk("R1 trap vector", 32'(vector_o), 32'h0024);
        chk("R1 trap vec_valid", 32'(vec_valid_o), 1);
        chk("R4 trap hold", 32'(pc_hold_o), 1);
        trap_i = 0;
        tick();
        chk("R4 hold one cycle", 32'(pc_hold_o), 0);

        arm(); mwrite(8'h08);
        chk("R9 R12 unmask status", 32'(status_o), 32'h08);

        rq_mid_i = 1; rq_lo_i = 1; gen_req_i = 1; strobe();
        chk("R2 R8 middle wins", 32'(vector_o), 32'h0034);
        chk("R5 flag cleared on accept", 32'(status_o[3]), 0);
        arm(); rq_mid_i = 0; strobe();
        chk("R2 R8 low wins", 32'(vector_o), 32'h002C);
        arm(); rq_lo_i = 0; strobe();
        chk("R7 gen ack", 32'(gen_ack_o), 1);
        chk("R7 gen no vector", 32'({vec_valid_o, vector_o}), 0);
        gen_req_i = 0;

        rq_hi_i = 1; tick(); rq_hi_i = 0; tick();
        chk("R11 high latched after pulse", 32'(status_o[6]), 1);
        arm(); rq_lo_i = 1; gen_req_i = 1; strobe();
        chk("R2 R8 high wins", 32'(vector_o), 32'h003C);
        chk("R11 high cleared on service", 32'(status_o[6]), 0);
        rq_lo_i = 0; gen_req_i = 0;

        rq_hi_i = 1; tick(); rq_hi_i = 0; tick();
        mwrite(8'h10);
        chk("R10 clear latched high", 32'(status_o[6]), 0);
        chk("R9 masks kept without bit 3", 32'(status_o[2:0]), 0);

        mwrite(8'h0F);
        arm(); rq_mid_i = 1; strobe();
        chk("R6 R9 masked middle ignored", 32'(pc_hold_o), 0);
        mwrite(8'h04);
        chk("R9 masks unchanged bit 3 clear", 32'(status_o[2:0]), 32'h7);
        rq_mid_i = 0;

        trap_i = 1; tick(); tick();
        chk("R3 no strobe no accept", 32'(pc_hold_o), 0);
        trap_i = 0;

        ie_set_i = 1; ie_clr_i = 1; tick();
        chk("R5 clear wins over set", 32'(status_o[3]), 0);

        // random phase checked by the model
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            sample_i    = ($urandom % 4) == 0;
            trap_i      = ($urandom % 16) == 0;
            rq_hi_i     = ($urandom % 3) == 0;
            rq_mid_i    = ($urandom % 4) == 0;
            rq_lo_i     = ($urandom % 4) == 0;
            gen_req_i   = ($urandom % 3) == 0;
            ie_set_i    = ($urandom % 2) == 0;
            ie_clr_i    = ($urandom % 12) == 0;
            mask_wr_i   = ($urandom % 8) == 0;
            mask_data_i = 8'($urandom);
        end
        tick();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule